// File: doc/BRIEF.md
# Packed-Nibble Rectangle Blit Engine

This block copies a rectangular area of pixels from one 4-bit-per-pixel bitmap into another. Both bitmaps are stored in memory as 16-bit words, with four pixels in each word. For every destination pixel, the engine unpacks the source pixel and the destination pixel at the same position in the rectangle. It sends both to an external combine unit, together with the parity of the destination pixel's X and Y. The nibble that comes back replaces the destination pixel inside a held copy of the destination word. The held word is written back when the engine moves past it (read-modify-write). Because the combine unit can return different values for the four X/Y parity classes, a dither texture can be painted with a small palette.

The engine needs the following inputs for each bitmap: base address, raster width in words, height in lines, width in pixels, and the coordinates of the rectangle's corner. It also needs the transfer width and height, plus a resume width. Lines are processed starting from the last line of the rectangle and working back. A single remaining-line count steers the address of every line. A page fault on any memory access is signalled on an abort input. The engine then stops and reports how many pixels of the current line, and how many lines, are still uncommitted. Starting the engine again with those two values as the resume width and the transfer height finishes the job exactly. An interrupt request is honoured only between lines.

Top module: `nibble_blit`

## Requirements
- R1: A word holds four 4-bit pixels. Pixel X of a row lies in word X/4 of that row, in nibble position X mod 4. Position 0 is bits [15:12], position 1 is bits [11:8], position 2 is bits [7:4] and position 3 is bits [3:0].
- R2: For each destination pixel, `cmbSrc` carries the source nibble and `cmbDst` the current destination nibble. `cmbSel` equals {Y[0], X[0]} of the destination pixel (bit 1 is the Y parity, bit 0 is the X parity). The `cmbOut` nibble replaces that pixel, and the other nibbles of the word keep their values.
- R3: The source and destination nibble positions advance independently. A source word is read again only when the source position passes 3. The destination word is written back and the next one read when the destination position passes 3. At the end of a line, the partly processed destination word is written back.
- R4: Lines are processed from Y+height-1 down to Y. The row address is base + (bitmap_height - (Y + lines_left)) × raster_width + X/4, where lines_left counts the current line.
- R5: A resume width of 0 starts every line at offset 0 of the rectangle. A nonzero resume width W processes only the last W pixels of the first line (offset width-W), and all later lines in full. A resume width larger than the transfer width is an error.
- R6: When `abortIn` is high while a memory request is waiting for acknowledge, the engine drops the request and pulses `aborted`. `remPixels` then gives the pixels of the current line not yet written to memory, and `remLines` gives the lines left including the current one. Restarting with these values as resume width and height gives the same final memory as an uninterrupted run.
- R7: Before any memory access, the engine checks the following, and on any failure pulses `err` with no memory request: Y < height and Y+transfer_height <= height for both bitmaps, X < width and X+transfer_width <= width (in pixels) for both bitmaps, and the R5 rule.
- R8: `irqReq` is sampled only after the end-of-line write of a line that is not the last. If it is set, the engine pulses `intStop` with `remPixels`=0 and `remLines` equal to the lines still to do.
- R9: A transfer width or height of zero pulses `done` with no memory request.
- R10: At most one request is outstanding: `memRd` and `memWr` are never high together. A request keeps its address and write data stable until `memAck` or an abort.
- R11: After reset the engine is idle: `busy`, `memRd`, `memWr`, `done`, `err`, `aborted` and `intStop` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer with the present parameters (taken when idle) |
| srcBase | input | ADDR_W | Word address of the source bitmap's first stored row |
| srcRaster | input | DIM_W | Source row pitch in words |
| srcHeight | input | DIM_W | Source bitmap height in lines |
| srcWidthPx | input | DIM_W | Source bitmap width in pixels |
| srcX | input | DIM_W | Source rectangle corner X |
| srcY | input | DIM_W | Source rectangle corner Y |
| dstBase | input | ADDR_W | Word address of the destination bitmap's first stored row |
| dstRaster | input | DIM_W | Destination row pitch in words |
| dstHeight | input | DIM_W | Destination bitmap height in lines |
| dstWidthPx | input | DIM_W | Destination bitmap width in pixels |
| dstX | input | DIM_W | Destination rectangle corner X |
| dstY | input | DIM_W | Destination rectangle corner Y |
| xferWidth | input | DIM_W | Rectangle width in pixels |
| xferHeight | input | DIM_W | Rectangle height in lines |
| resumeWidth | input | DIM_W | Pixels left in the first line, 0 for a fresh start |
| irqReq | input | 1 | Interrupt request, honoured between lines |
| abortIn | input | 1 | Fault on the pending memory request |
| memRd | output | 1 | Read request strobe |
| memWr | output | 1 | Write request strobe |
| memAddr | output | ADDR_W | Word address of the request |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid with memAck |
| memAck | input | 1 | Request completed |
| cmbValid | output | 1 | A pixel is being combined this cycle |
| cmbSrc | output | 4 | Source pixel to the combine unit |
| cmbDst | output | 4 | Destination pixel to the combine unit |
| cmbSel | output | 2 | {Y parity, X parity} of the destination pixel |
| cmbOut | input | 4 | Combined pixel from the combine unit |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse: transfer complete |
| err | output | 1 | One-cycle pulse: parameter check failed |
| aborted | output | 1 | One-cycle pulse: stopped by a fault |
| intStop | output | 1 | One-cycle pulse: stopped for an interrupt |
| remPixels | output | DIM_W | Uncommitted pixels of the current line |
| remLines | output | DIM_W | Lines left, including the current one |

## Verification
The assertions check the following on every cycle: the request handshake (a single strobe, with address and data held while waiting), that only one stop reason is reported at a time, that an error comes only from the parameter check, and that the pixel and line counters are never stepped past zero. Several behaviours can only be shown by the bench's scenarios, which compare all of memory against a pixel-level model: correct nibble placement for mismatched source and destination alignments, the end-of-line partial write, the bottom-up line order, and the exact continuation after an abort or interrupt. The scenarios also show that rejected or empty transfers leave memory untouched and issue no request.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int WORD_W = 16;
  localparam int PIX_W = 4;
  localparam int PIX_PER_WORD = WORD_W / PIX_W;
  localparam int POS_W = $clog2(PIX_PER_WORD);

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_LINE, S_RDDST, S_RDSRC, S_PIX, S_WRDST, S_WREND
  } blitState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // latch parameters
    logic lineInit;  // compute line addresses and alignments
    logic capDst;    // capture destination word
    logic capSrc;    // capture source word
    logic pixStep;   // merge one combined pixel
    logic dstAdv;    // destination word committed, move to next
    logic lineDone;  // end-of-line write committed
    logic selSrc;    // address mux selects source
  } blitCtl_t;

  // bit offset of nibble position pos, position 0 is most significant
  function automatic int nibShift(input logic [POS_W-1:0] pos);
    return (PIX_PER_WORD - 1 - int'(pos)) * PIX_W;
  endfunction
endpackage

// File: rtl/blit_datapath.sv
module blit_datapath
  import blit_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DIM_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  blitCtl_t          ctl,
  input  logic [ADDR_W-1:0] srcBase,
  input  logic [DIM_W-1:0]  srcRaster,
  input  logic [DIM_W-1:0]  srcHeight,
  input  logic [DIM_W-1:0]  srcWidthPx,
  input  logic [DIM_W-1:0]  srcX,
  input  logic [DIM_W-1:0]  srcY,
  input  logic [ADDR_W-1:0] dstBase,
  input  logic [DIM_W-1:0]  dstRaster,
  input  logic [DIM_W-1:0]  dstHeight,
  input  logic [DIM_W-1:0]  dstWidthPx,
  input  logic [DIM_W-1:0]  dstX,
  input  logic [DIM_W-1:0]  dstY,
  input  logic [DIM_W-1:0]  xferWidth,
  input  logic [DIM_W-1:0]  xferHeight,
  input  logic [DIM_W-1:0]  resumeWidth,
  input  logic [WORD_W-1:0] memRdata,
  input  logic [PIX_W-1:0]  cmbOut,
  output logic              zeroXfer,
  output logic              boundsOk,
  output logic              lastPix,
  output logic              lastLine,
  output logic              srcWrap,
  output logic              dstWrap,
  output logic              needSrc,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [PIX_W-1:0]  cmbSrc,
  output logic [PIX_W-1:0]  cmbDst,
  output logic [1:0]        cmbSel,
  output logic [DIM_W-1:0]  remPixels,
  output logic [DIM_W-1:0]  remLines
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(PIX_PER_WORD - 1);

  logic [ADDR_W-1:0] sBase, dBase, srcAddr, dstAddr;
  logic [DIM_W-1:0] sRast, sHt, sPxW, sX, sY;
  logic [DIM_W-1:0] dRast, dHt, dPxW, dX, dY;
  logic [DIM_W-1:0] xW, xH, resW;
  logic [DIM_W-1:0] linesRem, cnt, snap;
  logic [POS_W-1:0] srcPos, dstPos;
  logic [WORD_W-1:0] srcWord, dstWord;
  logic firstLine, yPar;

  // parameter checks on latched values
  logic [DIM_W:0] sEndY, sEndX, dEndY, dEndX;
  logic srcOk, dstOk;
  always_comb begin
    sEndY = {1'b0, sY} + {1'b0, xH};
    sEndX = {1'b0, sX} + {1'b0, xW};
    dEndY = {1'b0, dY} + {1'b0, xH};
    dEndX = {1'b0, dX} + {1'b0, xW};
    srcOk = (sY < sHt) && (sEndY <= {1'b0, sHt}) && (sX < sPxW) && (sEndX <= {1'b0, sPxW});
    dstOk = (dY < dHt) && (dEndY <= {1'b0, dHt}) && (dX < dPxW) && (dEndX <= {1'b0, dPxW});
    boundsOk = srcOk && dstOk && (resW <= xW);
    zeroXfer = (xW == '0) || (xH == '0);
  end

  // per-line start values
  logic resumeNow;
  logic [DIM_W-1:0] xOff, lineCnt, sxStart, dxStart;
  always_comb begin
    resumeNow = firstLine && (resW != '0);
    xOff = resumeNow ? (xW - resW) : '0;
    lineCnt = resumeNow ? resW : xW;
    sxStart = sX + xOff;
    dxStart = dX + xOff;
  end

  function automatic logic [ADDR_W-1:0] rowAddr(
    input logic [ADDR_W-1:0] base, input logic [DIM_W-1:0] ht,
    input logic [DIM_W-1:0] y, input logic [DIM_W-1:0] rem,
    input logic [DIM_W-1:0] rast, input logic [DIM_W-1:0] x);
    logic [ADDR_W-1:0] row;
    row = ADDR_W'(ht) - ADDR_W'(y) - ADDR_W'(rem);
    return base + row * ADDR_W'(rast) + ADDR_W'(x >> POS_W);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sBase <= '0; dBase <= '0; srcAddr <= '0; dstAddr <= '0;
      sRast <= '0; sHt <= '0; sPxW <= '0; sX <= '0; sY <= '0;
      dRast <= '0; dHt <= '0; dPxW <= '0; dX <= '0; dY <= '0;
      xW <= '0; xH <= '0; resW <= '0;
      linesRem <= '0; cnt <= '0; snap <= '0;
      srcPos <= '0; dstPos <= '0; srcWord <= '0; dstWord <= '0;
      firstLine <= 1'b0; yPar <= 1'b0; needSrc <= 1'b0;
    end else begin
      if (ctl.load) begin
        sBase <= srcBase; sRast <= srcRaster; sHt <= srcHeight; sPxW <= srcWidthPx;
        sX <= srcX; sY <= srcY;
        dBase <= dstBase; dRast <= dstRaster; dHt <= dstHeight; dPxW <= dstWidthPx;
        dX <= dstX; dY <= dstY;
        xW <= xferWidth; xH <= xferHeight; resW <= resumeWidth;
        linesRem <= xferHeight;
        snap <= resumeWidth;
        firstLine <= 1'b1;
      end
      if (ctl.lineInit) begin
        srcAddr <= rowAddr(sBase, sHt, sY, linesRem, sRast, sxStart);
        dstAddr <= rowAddr(dBase, dHt, dY, linesRem, dRast, dxStart);
        srcPos <= sxStart[POS_W-1:0];
        dstPos <= dxStart[POS_W-1:0];
        cnt <= lineCnt;
        snap <= lineCnt;
        firstLine <= 1'b0;
        needSrc <= 1'b1;
        yPar <= dY[0] ^ linesRem[0] ^ 1'b1;  // parity of dY + linesRem - 1
      end
      if (ctl.capDst) begin
        dstWord <= memRdata;
        snap <= cnt;
      end
      if (ctl.capSrc) begin
        srcWord <= memRdata;
        needSrc <= 1'b0;
      end
      if (ctl.pixStep) begin
        dstWord[nibShift(dstPos) +: PIX_W] <= cmbOut;
        cnt <= cnt - 1'b1;
        srcPos <= srcPos + 1'b1;
        dstPos <= dstPos + 1'b1;
        if (srcWrap) begin
          srcAddr <= srcAddr + 1'b1;
          needSrc <= 1'b1;
        end
      end
      if (ctl.dstAdv) begin
        dstAddr <= dstAddr + 1'b1;
        snap <= cnt;
      end
      if (ctl.lineDone) begin
        linesRem <= linesRem - 1'b1;
        snap <= '0;
      end
    end
  end

  always_comb begin
    lastPix = (cnt == DIM_W'(1));
    lastLine = (linesRem == DIM_W'(1));
    srcWrap = (srcPos == LAST_POS);
    dstWrap = (dstPos == LAST_POS);
    memAddr = ctl.selSrc ? srcAddr : dstAddr;
    memWdata = dstWord;
    cmbSrc = srcWord[nibShift(srcPos) +: PIX_W];
    cmbDst = dstWord[nibShift(dstPos) +: PIX_W];
    cmbSel = {yPar, dstPos[0]};
    remPixels = snap;
    remLines = linesRem;
  end

  // a pixel is only merged while pixels of the line remain (R3)
  assert_cnt_live_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pixStep |-> (cnt != '0));

  // a line only completes while lines remain (R4)
  assert_line_live_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.lineDone |-> (linesRem != '0));
endmodule

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     memAck,
  input  logic     abortIn,
  input  logic     irqReq,
  input  logic     zeroXfer,
  input  logic     boundsOk,
  input  logic     lastPix,
  input  logic     lastLine,
  input  logic     srcWrap,
  input  logic     dstWrap,
  input  logic     needSrc,
  output blitCtl_t ctl,
  output logic     memRd,
  output logic     memWr,
  output logic     busy,
  output logic     done,
  output logic     err,
  output logic     aborted,
  output logic     intStop
);
  blitState_t state, stateNext;
  logic doneNext, errNext, abortNext, intNext;

  always_comb begin
    stateNext = state;
    ctl = '0;
    doneNext = 1'b0;
    errNext = 1'b0;
    abortNext = 1'b0;
    intNext = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.load = 1'b1;
        stateNext = S_CHECK;
      end
      S_CHECK: begin
        if (zeroXfer) begin
          doneNext = 1'b1;
          stateNext = S_IDLE;
        end else if (!boundsOk) begin
          errNext = 1'b1;
          stateNext = S_IDLE;
        end else begin
          stateNext = S_LINE;
        end
      end
      S_LINE: begin
        ctl.lineInit = 1'b1;
        stateNext = S_RDDST;
      end
      S_RDDST: begin
        if (memAck) begin
          ctl.capDst = 1'b1;
          stateNext = needSrc ? S_RDSRC : S_PIX;
        end else if (abortIn) begin
          abortNext = 1'b1;
          stateNext = S_IDLE;
        end
      end
      S_RDSRC: begin
        ctl.selSrc = 1'b1;
        if (memAck) begin
          ctl.capSrc = 1'b1;
          stateNext = S_PIX;
        end else if (abortIn) begin
          abortNext = 1'b1;
          stateNext = S_IDLE;
        end
      end
      S_PIX: begin
        ctl.pixStep = 1'b1;
        if (lastPix) stateNext = S_WREND;
        else if (dstWrap) stateNext = S_WRDST;
        else if (srcWrap) stateNext = S_RDSRC;
      end
      S_WRDST: begin
        if (memAck) begin
          ctl.dstAdv = 1'b1;
          stateNext = S_RDDST;
        end else if (abortIn) begin
          abortNext = 1'b1;
          stateNext = S_IDLE;
        end
      end
      S_WREND: begin
        if (memAck) begin
          ctl.lineDone = 1'b1;
          if (lastLine) begin
            doneNext = 1'b1;
            stateNext = S_IDLE;
          end else if (irqReq) begin
            intNext = 1'b1;
            stateNext = S_IDLE;
          end else begin
            stateNext = S_LINE;
          end
        end else if (abortIn) begin
          abortNext = 1'b1;
          stateNext = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      done <= 1'b0;
      err <= 1'b0;
      aborted <= 1'b0;
      intStop <= 1'b0;
    end else begin
      state <= stateNext;
      done <= doneNext;
      err <= errNext;
      aborted <= abortNext;
      intStop <= intNext;
    end
  end

  always_comb begin
    memRd = (state == S_RDDST) || (state == S_RDSRC);
    memWr = (state == S_WRDST) || (state == S_WREND);
    busy = (state != S_IDLE);
  end

  // only one reason for stopping is reported at a time (R6, R8)
  assert_one_event_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, err, aborted, intStop}));

  // an error comes straight out of the parameter check, before any access (R7)
  assert_err_from_check_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> $past(state == S_CHECK));
endmodule

// File: rtl/nibble_blit.sv
module nibble_blit
  import blit_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DIM_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] srcBase,
  input  logic [DIM_W-1:0]  srcRaster,
  input  logic [DIM_W-1:0]  srcHeight,
  input  logic [DIM_W-1:0]  srcWidthPx,
  input  logic [DIM_W-1:0]  srcX,
  input  logic [DIM_W-1:0]  srcY,
  input  logic [ADDR_W-1:0] dstBase,
  input  logic [DIM_W-1:0]  dstRaster,
  input  logic [DIM_W-1:0]  dstHeight,
  input  logic [DIM_W-1:0]  dstWidthPx,
  input  logic [DIM_W-1:0]  dstX,
  input  logic [DIM_W-1:0]  dstY,
  input  logic [DIM_W-1:0]  xferWidth,
  input  logic [DIM_W-1:0]  xferHeight,
  input  logic [DIM_W-1:0]  resumeWidth,
  input  logic              irqReq,
  input  logic              abortIn,
  output logic              memRd,
  output logic              memWr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWdata,
  input  logic [15:0]       memRdata,
  input  logic              memAck,
  output logic              cmbValid,
  output logic [3:0]        cmbSrc,
  output logic [3:0]        cmbDst,
  output logic [1:0]        cmbSel,
  input  logic [3:0]        cmbOut,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              aborted,
  output logic              intStop,
  output logic [DIM_W-1:0]  remPixels,
  output logic [DIM_W-1:0]  remLines
);
  blitCtl_t ctl;
  logic zeroXfer, boundsOk, lastPix, lastLine, srcWrap, dstWrap, needSrc;

  blit_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .memAck(memAck), .abortIn(abortIn),
    .irqReq(irqReq), .zeroXfer(zeroXfer), .boundsOk(boundsOk), .lastPix(lastPix),
    .lastLine(lastLine), .srcWrap(srcWrap), .dstWrap(dstWrap), .needSrc(needSrc),
    .ctl(ctl), .memRd(memRd), .memWr(memWr), .busy(busy), .done(done), .err(err),
    .aborted(aborted), .intStop(intStop)
  );

  blit_datapath #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .srcBase(srcBase), .srcRaster(srcRaster), .srcHeight(srcHeight),
    .srcWidthPx(srcWidthPx), .srcX(srcX), .srcY(srcY),
    .dstBase(dstBase), .dstRaster(dstRaster), .dstHeight(dstHeight),
    .dstWidthPx(dstWidthPx), .dstX(dstX), .dstY(dstY),
    .xferWidth(xferWidth), .xferHeight(xferHeight), .resumeWidth(resumeWidth),
    .memRdata(memRdata), .cmbOut(cmbOut),
    .zeroXfer(zeroXfer), .boundsOk(boundsOk), .lastPix(lastPix), .lastLine(lastLine),
    .srcWrap(srcWrap), .dstWrap(dstWrap), .needSrc(needSrc),
    .memAddr(memAddr), .memWdata(memWdata), .cmbSrc(cmbSrc), .cmbDst(cmbDst),
    .cmbSel(cmbSel), .remPixels(remPixels), .remLines(remLines)
  );

  assign cmbValid = ctl.pixStep;

  // never a read and a write at once (R10)
  assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  // a waiting read keeps its address (R10)
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !memAck && !abortIn) |=> (memRd && $stable(memAddr)));

  // a waiting write keeps its address and data (R10)
  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && !memAck && !abortIn) |=> (memWr && $stable(memAddr) && $stable(memWdata)));
endmodule

// File: tb/nibble_blit_tb.sv
module nibble_blit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SBASE = 'h040, SRAST = 4, SHT = 12, SPXW = 16;
  localparam int DBASE = 'h100, DRAST = 5, DHT = 10, DPXW = 20;
  localparam int NVEC = 9;
  // sX sY dX dY W H latency outcome(0 done,1 err)
  localparam int VEC[NVEC][8] = '{
    '{0, 0, 0, 0,  4, 1, 0, 0},
    '{3, 2, 1, 3,  9, 4, 1, 0},
    '{2, 1, 6, 0, 13, 5, 2, 0},
    '{0, 4, 4, 7, 16, 3, 0, 0},
    '{0, 0, 5, 0, 16, 1, 0, 1},
    '{0,10, 0, 0,  2, 3, 0, 1},
    '{0, 0, 0,10,  2, 1, 0, 1},
    '{0, 0, 0, 0,  0, 2, 0, 0},
    '{0, 0, 0, 0,  3, 0, 1, 0}
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [15:0] srcBase, dstBase;
  logic [11:0] srcRaster, srcHeight, srcWidthPx, srcX, srcY;
  logic [11:0] dstRaster, dstHeight, dstWidthPx, dstX, dstY;
  logic [11:0] xferWidth, xferHeight, resumeWidth, remPixels, remLines;
  logic irqReq = 1'b0, abortIn = 1'b0, memAck = 1'b0;
  logic memRd, memWr, cmbValid, busy, done, err, aborted, intStop;
  logic [15:0] memAddr, memWdata, memRdata = '0;
  logic [3:0] cmbSrc, cmbDst, cmbOut;
  logic [1:0] cmbSel;

  logic [15:0] mem [1024];
  logic [15:0] expm [1024];
  logic [15:0] base0 [1024];
  int checks = 0, fails = 0, accCnt = 0, bothCnt = 0, waitCnt = 0, latCfg = 0;
  int cyc = 0;
  logic faultArm = 1'b0;
  logic [15:0] faultAddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_blit u_dut (
    .clk(clk), .rstN(rstN), .start(start),
    .srcBase(srcBase), .srcRaster(srcRaster), .srcHeight(srcHeight), .srcWidthPx(srcWidthPx),
    .srcX(srcX), .srcY(srcY),
    .dstBase(dstBase), .dstRaster(dstRaster), .dstHeight(dstHeight), .dstWidthPx(dstWidthPx),
    .dstX(dstX), .dstY(dstY),
    .xferWidth(xferWidth), .xferHeight(xferHeight), .resumeWidth(resumeWidth),
    .irqReq(irqReq), .abortIn(abortIn),
    .memRd(memRd), .memWr(memWr), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck),
    .cmbValid(cmbValid), .cmbSrc(cmbSrc), .cmbDst(cmbDst), .cmbSel(cmbSel), .cmbOut(cmbOut),
    .busy(busy), .done(done), .err(err), .aborted(aborted), .intStop(intStop),
    .remPixels(remPixels), .remLines(remLines)
  );

  function automatic int cmbF(int s, int d, int sel);
    return (s * 3 + d * 5 + sel * 7 + 1) & 15;
  endfunction

  assign cmbOut = 4'(cmbF(int'(cmbSrc), int'(cmbDst), int'(cmbSel)));

  // memory model with latency and an optional write fault
  always @(posedge clk) begin
    memAck <= 1'b0;
    abortIn <= 1'b0;
    if (memRd && memWr) bothCnt <= bothCnt + 1;
    if ((memRd || memWr) && !memAck && !abortIn) begin
      if (faultArm && memWr && memAddr == faultAddr) begin
        abortIn <= 1'b1;
        faultArm <= 1'b0;
      end else if (waitCnt >= latCfg) begin
        memAck <= 1'b1;
        waitCnt <= 0;
        accCnt <= accCnt + 1;
        memRdata <= mem[memAddr[9:0]];
        if (memWr) mem[memAddr[9:0]] <= memWdata;
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int addrOf(int base, int ht, int rast, int x, int y);
    return base + (ht - 1 - y) * rast + x / 4;
  endfunction

  // pixel-level model of the combine: R1 packing, R2 select
  task automatic modelRect(int sx, int sy, int dx, int dy, int w, int h);
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < w; x++) begin
        int sa, da, s, d, r;
        sa = addrOf(SBASE, SHT, SRAST, sx + x, sy + y);
        da = addrOf(DBASE, DHT, DRAST, dx + x, dy + y);
        s = (int'(expm[sa]) >> (4 * (3 - (sx + x) % 4))) & 15;
        d = (int'(expm[da]) >> (4 * (3 - (dx + x) % 4))) & 15;
        r = cmbF(s, d, ((dy + y) % 2) * 2 + (dx + x) % 2);
        expm[da][4 * (3 - (dx + x) % 4) +: 4] = 4'(r);
      end
    end
  endtask

  task automatic memCheck(input string req);
    int bad, firstA;
    bad = 0; firstA = -1;
    for (int i = 0; i < 1024; i++)
      if (mem[i] !== expm[i]) begin
        bad++;
        if (firstA < 0) firstA = i;
      end
    chk(bad == 0, req, (firstA < 0) ? 0 : int'(mem[firstA]), (firstA < 0) ? 0 : int'(expm[firstA]));
  endtask

  task automatic snapMem();
    for (int i = 0; i < 1024; i++) begin
      expm[i] = mem[i];
      base0[i] = mem[i];
    end
  endtask

  task automatic restoreExp();
    for (int i = 0; i < 1024; i++) expm[i] = base0[i];
  endtask

  // returns 0 done, 1 err, 2 aborted, 3 interrupt stop, 4 timeout
  task automatic runOp(int sx, int sy, int dx, int dy, int w, int h, int res, output int outc);
    @(negedge clk);
    srcX = 12'(sx); srcY = 12'(sy); dstX = 12'(dx); dstY = 12'(dy);
    xferWidth = 12'(w); xferHeight = 12'(h); resumeWidth = 12'(res);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    outc = 4;
    for (int n = 0; n < 5000; n++) begin
      if (done) begin outc = 0; break; end
      if (err) begin outc = 1; break; end
      if (aborted) begin outc = 2; break; end
      if (intStop) begin outc = 3; break; end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int outc, acc0, expOut;
    string tag;
    srcBase = 16'(SBASE); srcRaster = 12'(SRAST); srcHeight = 12'(SHT); srcWidthPx = 12'(SPXW);
    dstBase = 16'(DBASE); dstRaster = 12'(DRAST); dstHeight = 12'(DHT); dstWidthPx = 12'(DPXW);
    srcX = '0; srcY = '0; dstX = '0; dstY = '0;
    xferWidth = '0; xferHeight = '0; resumeWidth = '0;
    for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 40503 + 12345);
    repeat (3) @(negedge clk);
    // R11: idle after reset
    chk(!busy && !memRd && !memWr && !done && !err && !aborted && !intStop, "R11 reset idle",
        int'({busy, memRd, memWr, done, err, aborted, intStop}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !memRd && !memWr, "R11 idle after release", int'({busy, memRd, memWr}), 0);

    // table of vectors
    for (int v = 0; v < NVEC; v++) begin
      latCfg = VEC[v][6];
      expOut = VEC[v][7];
      snapMem();
      if (expOut == 0 && VEC[v][4] != 0 && VEC[v][5] != 0)
        modelRect(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
      if (expOut == 1) tag = "R7";
      else if (VEC[v][4] == 0 || VEC[v][5] == 0) tag = "R9";
      else tag = "R2";
      acc0 = accCnt;
      runOp(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], 0, outc);
      chk(outc == expOut, $sformatf("%s outcome vec%0d", tag, v), outc, expOut);
      memCheck($sformatf("R1 R3 memory vec%0d", v));
      if (tag != "R2")
        chk(accCnt == acc0, $sformatf("%s no traffic vec%0d", tag, v), accCnt - acc0, 0);
    end

    // R5: resume wider than transfer is rejected
    latCfg = 0;
    snapMem();
    acc0 = accCnt;
    runOp(0, 0, 0, 0, 4, 2, 5, outc);
    chk(outc == 1, "R5 oversize resume err", outc, 1);
    chk(accCnt == acc0, "R5 oversize resume no traffic", accCnt - acc0, 0);

    // R8 / R4: interrupt between lines, first line done is the last one of the rect
    snapMem();
    modelRect(1, 3 + 2, 2, 1 + 2, 7, 1);
    irqReq = 1'b1;
    runOp(1, 3, 2, 1, 7, 3, 0, outc);
    irqReq = 1'b0;
    chk(outc == 3, "R8 interrupt stop", outc, 3);
    chk(remLines == 12'd2, "R8 lines left", int'(remLines), 2);
    chk(remPixels == 12'd0, "R8 pixels left", int'(remPixels), 0);
    memCheck("R4 bottom line first");
    restoreExp();
    modelRect(1, 3, 2, 1, 7, 3);
    runOp(1, 3, 2, 1, 7, 2, 0, outc);
    chk(outc == 0, "R8 continue done", outc, 0);
    memCheck("R8 continue memory");

    // R6: fault on the second destination word write of the first line
    latCfg = 1;
    snapMem();
    modelRect(2, 5 + 2, 1, 2 + 2, 3, 1);
    faultAddr = 16'(addrOf(DBASE, DHT, DRAST, 4, 2 + 2));
    faultArm = 1'b1;
    runOp(2, 5, 1, 2, 10, 3, 0, outc);
    chk(outc == 2, "R6 aborted", outc, 2);
    chk(remPixels == 12'd7, "R6 pixels left", int'(remPixels), 7);
    chk(remLines == 12'd3, "R6 lines left", int'(remLines), 3);
    memCheck("R6 committed part only");
    restoreExp();
    modelRect(2, 5, 1, 2, 10, 3);
    runOp(2, 5, 1, 2, 10, 3, 7, outc);
    chk(outc == 0, "R5 resume done", outc, 0);
    memCheck("R5 R6 resumed memory");

    chk(bothCnt == 0, "R10 single strobe", bothCnt, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule